// File: doc/BRIEF.md
# Infrared Remote-Control Frame Transmitter

This block turns a 32-bit remote-control word and a repeat count into the pulse-distance waveform that infrared remotes use. When it is idle, a one-cycle `start` latches the word and the count. The block then drives `tx_gate` high for every carrier burst and low for every space, and `tx_ir` carries the same pattern as a square-wave carrier gated by `tx_gate`. `busy` stays high for the whole transfer. `done` pulses once when the transfer ends.

All durations count in ticks, and one tick is `TICK_DIV` system clocks (one microsecond by default). A single period counter starts at the first edge of every frame. It pads both the data frame and each short repeat frame out to a fixed frame period of `FRAME_TICKS` ticks. After the data frame, each repeat is sent as a short repeat code, and the full word is never sent again.

Top module: `nec_ir_tx`

## Requirements
- R1: A `start` sampled high while `busy` is low makes `busy` and `tx_gate` high from the next cycle. The header is a burst of `HDR_MARK` ticks followed by a space of `HDR_SPACE` ticks.
- R2: A segment of N ticks keeps `tx_gate` at one level for exactly N×`TICK_DIV` clock cycles.
- R3: Every data bit is a burst of `BIT_MARK` ticks followed by a space. The space lasts `ZERO_SPACE` ticks for a 0 and `ONE_SPACE` ticks for a 1.
- R4: Bit i of `word_in` is the i-th bit sent (bit 0 first). The low byte (address) therefore goes first, then the address complement in bits 15:8, then the command in bits 23:16, then the command complement in bits 31:24, each byte least-significant bit first.
- R5: A stop burst of `BIT_MARK` ticks follows the 32nd bit. If the repeat count is zero, `tx_gate` and `busy` fall at the end of that burst, and `done` is high for exactly that one cycle.
- R6: If the repeat count is nonzero, `tx_gate` stays low after the stop burst until `FRAME_TICKS` ticks have passed since the frame's first burst began. A repeat frame then starts.
- R7: A repeat frame is a burst of `HDR_MARK` ticks, a space of `REP_SPACE` ticks and a stop burst of `BIT_MARK` ticks. It is padded to `FRAME_TICKS` when more repeats remain. After the last repeat's stop burst the block goes idle and pulses `done` at once, with no padding.
- R8: `tx_ir` is low whenever `tx_gate` is low. During a burst it follows a square wave that is high for `CARRIER_HALF` cycles and then low for `CARRIER_HALF` cycles, and this wave restarts high in the first cycle after `start`.
- R9: While `busy` is high, `start` is ignored. Changes on `word_in` or `repeat_in` after the start cycle do not alter the waveform.
- R10: After reset, `busy`, `done`, `tx_gate` and `tx_ir` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer; accepted only while idle |
| word_in | input | 32 | Word to send, bit 0 first |
| repeat_in | input | REP_W | Number of repeat frames after the data frame |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| tx_gate | output | 1 | High during carrier bursts |
| tx_ir | output | 1 | Carrier gated by `tx_gate` |

## Verification
The bench measures every high and low run of `tx_gate` in clock cycles and compares it with a schedule built from the parameters. A prescaler that is off by one would stretch every run by a multiple of the segment count. Swapped space lengths or MSB-first shifting would show up on the all-zero, all-one and single-set-bit words. The padding runs are checked after data frames of different lengths. A design that padded by a fixed amount, or that restarted the period counter in the wrong place, would produce a wrong pad length. After the last repeat the pad must be absent. A design that padded it would hold `busy` and delay `done` by about one frame. The bench also sends a second `start` with a different word in the middle of a transfer, which catches a design that reloads its state while busy.

// File: rtl/nec_ir_tx.sv
module nec_ir_tx #(
  parameter int TICK_DIV     = 250,
  parameter int HDR_MARK     = 9000,
  parameter int HDR_SPACE    = 4500,
  parameter int BIT_MARK     = 560,
  parameter int ZERO_SPACE   = 560,
  parameter int ONE_SPACE    = 1690,
  parameter int REP_SPACE    = 2250,
  parameter int FRAME_TICKS  = 108000,
  parameter int CARRIER_HALF = 3289,
  parameter int REP_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      word_in,
  input  logic [REP_W-1:0] repeat_in,
  output logic             busy,
  output logic             done,
  output logic             tx_gate,
  output logic             tx_ir
);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int TW = $clog2(FRAME_TICKS + 1);
  localparam int CW = $clog2(CARRIER_HALF + 1);

  typedef enum logic [1:0] {S_IDLE, S_HEAD, S_DATA, S_REPT} state_t;

  state_t           state;
  logic [PW-1:0]    pre;
  logic [TW-1:0]    seg_left, per_left;
  logic [5:0]       step;
  logic             pad, car;
  logic [CW-1:0]    car_cnt;
  logic [31:0]      word;
  logic [REP_W-1:0] reps;
  logic             tick, seg_end, per_end, adv;

  assign busy    = (state != S_IDLE);
  assign tick    = busy && (pre == PW'(TICK_DIV - 1));
  assign seg_end = tick && (seg_left == TW'(1));
  assign per_end = tick && (per_left == TW'(1));
  assign adv     = pad ? per_end : seg_end;
  assign tx_ir   = tx_gate & car;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pre      <= '0;
      seg_left <= '0;
      per_left <= '0;
      step     <= '0;
      pad      <= 1'b0;
      tx_gate  <= 1'b0;
      done     <= 1'b0;
      car      <= 1'b0;
      car_cnt  <= '0;
      word     <= 32'hA55A_11EE;
      reps     <= REP_W'(5);
    end else begin
      done <= 1'b0;

      if (state == S_IDLE && start) begin
        car     <= 1'b1;
        car_cnt <= '0;
      end else if (car_cnt == CW'(CARRIER_HALF - 1)) begin
        car     <= ~car;
        car_cnt <= '0;
      end else begin
        car_cnt <= car_cnt + 1'b1;
      end

      if (busy) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) begin
          seg_left <= seg_left - 1'b1;
          per_left <= (per_left == TW'(1)) ? TW'(FRAME_TICKS) : per_left - 1'b1;
        end
      end

      case (state)
        S_IDLE: if (start) begin
          word     <= word_in;
          reps     <= repeat_in;
          state    <= S_HEAD;
          step     <= '0;
          pad      <= 1'b0;
          tx_gate  <= 1'b1;
          pre      <= '0;
          seg_left <= TW'(HDR_MARK);
          per_left <= TW'(FRAME_TICKS);
        end
        S_HEAD: if (adv) begin
          if (step == 6'd0) begin
            step     <= 6'd1;
            tx_gate  <= 1'b0;
            seg_left <= TW'(HDR_SPACE);
          end else begin
            state    <= S_DATA;
            step     <= '0;
            tx_gate  <= 1'b1;
            seg_left <= TW'(BIT_MARK);
          end
        end
        S_DATA: if (adv) begin
          if (tx_gate) begin
            tx_gate <= 1'b0;
            if (step == 6'd32) begin
              if (reps == '0) begin
                state    <= S_IDLE;
                done     <= 1'b1;
                step     <= '0;
                pre      <= '0;
                seg_left <= '0;
                per_left <= '0;
              end else begin
                pad <= 1'b1;
              end
            end else begin
              seg_left <= word[step[4:0]] ? TW'(ONE_SPACE) : TW'(ZERO_SPACE);
            end
          end else if (pad) begin
            state    <= S_REPT;
            step     <= '0;
            pad      <= 1'b0;
            tx_gate  <= 1'b1;
            seg_left <= TW'(HDR_MARK);
          end else begin
            step     <= step + 1'b1;
            tx_gate  <= 1'b1;
            seg_left <= TW'(BIT_MARK);
          end
        end
        S_REPT: if (adv) begin
          case (step)
            6'd0: begin
              step     <= 6'd1;
              tx_gate  <= 1'b0;
              seg_left <= TW'(REP_SPACE);
            end
            6'd1: begin
              step     <= 6'd2;
              tx_gate  <= 1'b1;
              seg_left <= TW'(BIT_MARK);
            end
            6'd2: begin
              tx_gate <= 1'b0;
              reps    <= reps - 1'b1;
              if (reps == REP_W'(1)) begin
                state    <= S_IDLE;
                done     <= 1'b1;
                step     <= '0;
                pre      <= '0;
                seg_left <= '0;
                per_left <= '0;
              end else begin
                step <= 6'd3;
                pad  <= 1'b1;
              end
            end
            default: begin
              step     <= '0;
              pad      <= 1'b0;
              tx_gate  <= 1'b1;
              seg_left <= TW'(HDR_MARK);
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nec_ir_tx_sva.sv
module nec_ir_tx_sva (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic tx_gate,
  input logic tx_ir,
  input logic tick
);
  assert_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && tx_gate));

  assert_gate_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(tx_gate)) |-> $past(tick));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && !tx_gate));

  assert_idle_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_gate && !tx_ir));

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || $past(done)));
endmodule

bind nec_ir_tx nec_ir_tx_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .tx_gate(tx_gate), .tx_ir(tx_ir), .tick(tick)
);

// File: tb/nec_ir_tx_test.sv
module nec_ir_tx_test;
  localparam int TD = 4, HM = 8, HS = 4, BM = 2, ZS = 2, OS = 5, RS = 3, FR = 300, CH = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] word_in = '0;
  logic [7:0]  repeat_in = '0;
  logic busy, done, tx_gate, tx_ir;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  nec_ir_tx #(.TICK_DIV(TD), .HDR_MARK(HM), .HDR_SPACE(HS), .BIT_MARK(BM),
    .ZERO_SPACE(ZS), .ONE_SPACE(OS), .REP_SPACE(RS), .FRAME_TICKS(FR),
    .CARRIER_HALF(CH), .REP_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
    .repeat_in(repeat_in), .busy(busy), .done(done), .tx_gate(tx_gate), .tx_ir(tx_ir));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_run(input logic lvl, input int ticks, input bit car_chk, input string req);
    int n = 0;
    int bad = 0;
    while (tx_gate == lvl && n < ticks * TD + 8) begin
      if (!lvl && tx_ir) bad++;
      if (car_chk && tx_ir != (((n / CH) % 2) == 0)) bad++;
      n++;
      @(negedge clk);
    end
    check(n == ticks * TD, req, n, ticks * TD);
    if (bad != 0 || car_chk) check(bad == 0, "R8", bad, 0);
  endtask

  task automatic send(input logic [31:0] w, input int reps, input bit disturb);
    int el;
    @(negedge clk);
    word_in = w; repeat_in = 8'(reps); start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1, "R1", busy, 1);
    fork
      begin
        expect_run(1, HM, 1, "R1");
        expect_run(0, HS, 0, "R1");
        el = HM + HS;
        for (int i = 0; i < 32; i++) begin
          expect_run(1, BM, 0, "R3");
          expect_run(0, w[i] ? OS : ZS, 0, "R4");
          el += BM + (w[i] ? OS : ZS);
        end
        expect_run(1, BM, 0, "R5");
        el += BM;
        for (int r = 0; r < reps; r++) begin
          expect_run(0, FR - el, 0, "R6");
          expect_run(1, HM, 0, "R7");
          expect_run(0, RS, 0, "R7");
          expect_run(1, BM, 0, "R7");
          el = HM + RS + BM;
        end
      end
      begin
        if (disturb) begin
          repeat (60) @(negedge clk);
          word_in = ~w; repeat_in = 8'd3; start = 1;
          @(negedge clk);
          start = 0;
        end
      end
    join
    check(done == 1 && busy == 0, "R5 done at end", {done, busy}, 2);
    @(negedge clk);
    check(done == 0, "R5 single pulse", done, 0);
    check(tx_ir == 0 && tx_gate == 0, "R8 idle low", {tx_gate, tx_ir}, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && tx_gate == 0 && tx_ir == 0, "R10",
          {busy, done, tx_gate, tx_ir}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(busy == 0 && tx_gate == 0, "R10 after release", {busy, tx_gate}, 0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    send(32'h0000_0000, 0, 0);
    send(32'hFFFF_FFFF, 0, 0);
    send(32'h0000_0001, 1, 0);
    send(32'hA55A_11EE, 2, 0);
    send(32'h8000_0000, 0, 1);
    send(32'h35CA_E817, 1, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule